// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits beside the request port of a multi-threaded processor core and keeps track of every cache-line request that has been issued but has not yet completed. Each hardware thread owns two small fully associative tables: one for reads (loads and instruction fetches) and one for writes (stores and atomics). An entry holds the line address, with the byte offset dropped, and a flag that marks prefetches. Every table is searched in parallel in one cycle, both for the incoming request and for the incoming completion.

For each presented request the block reports `ready_o`. It is high only if three conditions hold: the global outstanding limit has not been reached, no table of any thread already holds that line, and the target table has a free slot. A valid request is accepted when ready. A store or atomic to a line for which its own thread already has a write entry is merged into that entry, whatever `ready_o` shows. Completions free the matching entry, or raise `err_o` if none exists. The block reports the outstanding and demand (non-prefetch) counts. A single watchdog is armed by an accepted request. If the watchdog expires while work is still pending, it latches a deadlock flag.

Top module: `omt_tracker`

## Requirements
- R1: Request type is encoded on `req_type_i` as 0 load, 1 instruction fetch, 2 store, 3 atomic (bit 1 set means write). Writes are entered in the issuing thread's write table and reads in its read table, so a completion is matched only against the table named by `cpl_write_i` for `cpl_thread_i`.
- R2: Entries are keyed by the line address `addr[ADDR_W-1:LINE_LG]`. Addresses that differ only in the low `LINE_LG` bits refer to the same entry.
- R3: `ready_o` is high exactly when all three hold: the outstanding count is below `MAX_OUT`, no read or write table of any thread holds the request's line, and the table the request would use has a free slot.
- R4: A request with `req_valid_i` and `ready_o` high is accepted (`accept_o` high in the same cycle). It allocates one entry, and `outstanding_o` is one higher after the next clock edge.
- R5: A store or atomic whose line already has a write entry for the same thread is accepted even while `ready_o` is low. It replaces that entry's prefetch flag and leaves `outstanding_o` unchanged.
- R6: A completion that finds its entry frees it, and `outstanding_o` is one lower after the next edge, for completions in any order.
- R7: A completion with no matching entry (wrong thread, wrong table or unknown line) drives `err_o` high in the same cycle and changes no state.
- R8: `demand_o` equals the number of occupied entries whose prefetch flag is clear, over all tables.
- R9: `outstanding_o` always equals the total number of occupied entries and never exceeds `MAX_OUT`.
- R10: An accepted request arms the watchdog if it is idle. `WDOG_CYCLES` edges later the watchdog disarms. If entries are still outstanding at that edge, `deadlock_o` is set and stays set until reset.
- R11: After reset all tables are empty, `outstanding_o`, `demand_o` and `deadlock_o` are 0, and `ready_o` is high.
- R12: When a merging store and the write completion for the same entry arrive in the same cycle, the store is accepted and the entry is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | ADDR_W | Request byte address |
| req_type_i | input | 2 | 0 load, 1 ifetch, 2 store, 3 atomic |
| req_thread_i | input | TID_W | Issuing thread |
| req_pf_i | input | 1 | Request is a prefetch |
| ready_o | output | 1 | A new entry may be allocated for the presented request |
| accept_o | output | 1 | Request taken this cycle (allocated or merged) |
| cpl_valid_i | input | 1 | Completion present |
| cpl_addr_i | input | ADDR_W | Completion byte address |
| cpl_thread_i | input | TID_W | Thread of the completed request |
| cpl_write_i | input | 1 | Completion is for a write-table entry |
| err_o | output | 1 | Completion found no matching entry |
| outstanding_o | output | CNT_W | Occupied entries over all tables |
| demand_o | output | CNT_W | Occupied non-prefetch entries |
| deadlock_o | output | 1 | Sticky watchdog expiry with work pending |

## Verification
Directed sequences separate the causes of a low `ready_o`: a line held by another thread, a full per-thread table, and the global limit. They also separate a merging store from a blocked one, and a completion aimed at the wrong table or thread from a valid one. Merges that flip the prefetch flag show that `demand_o` follows the flag and not only the occupancy. A merge and a completion of the same entry in one cycle pin down their priority. A long random run over a handful of lines, threads and types drives out-of-order completions, bogus completions and repeated watchdog expiry, and is compared cycle by cycle against a scoreboard model of the tables.

// File: rtl/omt_pkg.sv
package omt_pkg;
  typedef enum logic [1:0] {
    REQ_LOAD   = 2'b00,
    REQ_IFETCH = 2'b01,
    REQ_STORE  = 2'b10,
    REQ_ATOMIC = 2'b11
  } req_kind_e;

  function automatic logic kind_is_write(req_kind_e k);
    return (k == REQ_STORE) || (k == REQ_ATOMIC);
  endfunction
endpackage

// File: rtl/omt_table.sv
module omt_table #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned TAG_W   = 12,
  localparam int unsigned ECW    = $clog2(ENTRIES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] rq_tag_i,
  input  logic [TAG_W-1:0] cp_tag_i,
  input  logic             alloc_i,
  input  logic             upd_i,
  input  logic             free_i,
  input  logic             pf_i,
  output logic             rq_hit_o,
  output logic             cp_hit_o,
  output logic             full_o,
  output logic [ECW-1:0]   occ_o,
  output logic [ECW-1:0]   dem_o
);
  logic [ENTRIES-1:0] vld_q, pf_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] rq_match, cp_match, free_oh;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      rq_match[i] = vld_q[i] && (tag_q[i] == rq_tag_i);
      cp_match[i] = vld_q[i] && (tag_q[i] == cp_tag_i);
    end
  end

  // lowest free slot, one-hot
  always_comb begin
    free_oh = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_oh    = '0;
        free_oh[i] = 1'b1;
      end
    end
  end

  always_comb begin
    occ_o = '0;
    dem_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      occ_o = occ_o + ECW'(vld_q[i]);
      dem_o = dem_o + ECW'(vld_q[i] && !pf_q[i]);
    end
  end

  assign rq_hit_o = |rq_match;
  assign cp_hit_o = |cp_match;
  assign full_o   = &vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      pf_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc_i && free_oh[i]) begin
          vld_q[i] <= 1'b1;
          pf_q[i]  <= pf_i;
        end else if (upd_i && rq_match[i]) begin
          pf_q[i]  <= pf_i;
        end
        // free wins over a same-cycle merge
        if (free_i && cp_match[i]) vld_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < ENTRIES; i++)
      if (alloc_i && free_oh[i]) tag_q[i] <= rq_tag_i;
  end
endmodule

// File: rtl/omt_watchdog.sv
module omt_watchdog #(
  parameter int unsigned THRESH = 64,
  localparam int unsigned CW    = (THRESH > 1) ? $clog2(THRESH) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic busy_i,
  output logic deadlock_o
);
  logic          armed_q, dl_q;
  logic [CW-1:0] cnt_q;
  logic          fire;

  assign fire       = armed_q && (cnt_q == CW'(THRESH - 1));
  assign deadlock_o = dl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      dl_q    <= 1'b0;
    end else if (fire) begin
      armed_q <= 1'b0;
      if (busy_i) dl_q <= 1'b1;
    end else if (armed_q) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (start_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end
  end
endmodule

// File: rtl/omt_tracker.sv
module omt_tracker
  import omt_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 2,
  parameter int unsigned ENTRIES     = 4,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned LINE_LG     = 4,
  parameter int unsigned MAX_OUT     = 6,
  parameter int unsigned WDOG_CYCLES = 64,
  localparam int unsigned TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int unsigned TAG_W = ADDR_W - LINE_LG,
  localparam int unsigned NTAB  = 2 * NUM_THREADS,
  localparam int unsigned TOT   = NTAB * ENTRIES,
  localparam int unsigned CNT_W = $clog2(TOT + 1),
  localparam int unsigned ECW   = $clog2(ENTRIES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_type_i,
  input  logic [TID_W-1:0]  req_thread_i,
  input  logic              req_pf_i,
  output logic              ready_o,
  output logic              accept_o,
  input  logic              cpl_valid_i,
  input  logic [ADDR_W-1:0] cpl_addr_i,
  input  logic [TID_W-1:0]  cpl_thread_i,
  input  logic              cpl_write_i,
  output logic              err_o,
  output logic [CNT_W-1:0]  outstanding_o,
  output logic [CNT_W-1:0]  demand_o,
  output logic              deadlock_o
);
  logic [TAG_W-1:0] rq_tag, cp_tag;
  logic             is_wr, thr_ok;
  logic [TID_W:0]   tgt, own_wr, ctgt;
  logic [NTAB-1:0]  rq_hit, cp_hit, full, alloc, upd, free;
  logic [NTAB-1:0]  tgt_oh, own_oh, ctgt_oh;
  logic [ECW-1:0]   occ [NTAB];
  logic [ECW-1:0]   dem [NTAB];
  logic [CNT_W-1:0] count_q, occ_sum, dem_sum;
  logic             coalesce, alloc_go, cpl_ok;
  logic             unused_lo;

  assign unused_lo = ^{req_addr_i[LINE_LG-1:0], cpl_addr_i[LINE_LG-1:0]};

  assign rq_tag = req_addr_i[ADDR_W-1:LINE_LG];
  assign cp_tag = cpl_addr_i[ADDR_W-1:LINE_LG];
  assign is_wr  = kind_is_write(req_kind_e'(req_type_i));
  assign thr_ok = 32'(req_thread_i) < NUM_THREADS;
  // table index: thread*2 + (1 for write table)
  assign tgt    = {req_thread_i, is_wr};
  assign own_wr = {req_thread_i, 1'b1};
  assign ctgt   = {cpl_thread_i, cpl_write_i};

  for (genvar g = 0; g < NTAB; g++) begin : g_tab
    assign tgt_oh[g]  = (tgt == (TID_W + 1)'(g));
    assign own_oh[g]  = (own_wr == (TID_W + 1)'(g));
    assign ctgt_oh[g] = (ctgt == (TID_W + 1)'(g));
    assign alloc[g]   = alloc_go && tgt_oh[g];
    assign upd[g]     = coalesce && own_oh[g];
    assign free[g]    = cpl_ok && ctgt_oh[g];

    omt_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_tab (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rq_tag_i (rq_tag),
      .cp_tag_i (cp_tag),
      .alloc_i  (alloc[g]),
      .upd_i    (upd[g]),
      .free_i   (free[g]),
      .pf_i     (req_pf_i),
      .rq_hit_o (rq_hit[g]),
      .cp_hit_o (cp_hit[g]),
      .full_o   (full[g]),
      .occ_o    (occ[g]),
      .dem_o    (dem[g])
    );
  end

  always_comb begin
    occ_sum = '0;
    dem_sum = '0;
    for (int i = 0; i < NTAB; i++) begin
      occ_sum = occ_sum + CNT_W'(occ[i]);
      dem_sum = dem_sum + CNT_W'(dem[i]);
    end
  end

  assign ready_o  = thr_ok && (32'(count_q) < MAX_OUT) && !(|rq_hit) && !(|(full & tgt_oh));
  assign coalesce = req_valid_i && is_wr && thr_ok && (|(rq_hit & own_oh));
  assign alloc_go = req_valid_i && ready_o;
  assign accept_o = alloc_go || coalesce;

  assign cpl_ok = cpl_valid_i && (|(cp_hit & ctgt_oh));
  assign err_o  = cpl_valid_i && !cpl_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_q + CNT_W'(alloc_go) - CNT_W'(cpl_ok);
  end

  assign outstanding_o = count_q;
  assign demand_o      = dem_sum;

  omt_watchdog #(.THRESH(WDOG_CYCLES)) u_wdog (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept_o),
    .busy_i     (occ_sum != '0),
    .deadlock_o (deadlock_o)
  );
endmodule

// File: rtl/omt_tracker_chk.sv
module omt_tracker_chk #(
  parameter int unsigned MAX_OUT = 6,
  parameter int unsigned CNT_W   = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [1:0]       req_type_i,
  input logic             ready_o,
  input logic             accept_o,
  input logic             cpl_valid_i,
  input logic             err_o,
  input logic [CNT_W-1:0] outstanding_o,
  input logic [CNT_W-1:0] demand_o,
  input logic             deadlock_o,
  input logic [CNT_W-1:0] occ_sum_i
);
  assert_count_matches_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outstanding_o == occ_sum_i);

  assert_count_bounded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(outstanding_o) <= MAX_OUT);

  assert_limit_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(outstanding_o) >= MAX_OUT) |-> !ready_o);

  assert_merge_only_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !ready_o) |-> req_type_i[1]);

  assert_accept_needs_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> req_valid_i);

  assert_alloc_counts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ready_o && !cpl_valid_i) |=> outstanding_o == $past(outstanding_o) + 1'b1);

  assert_free_counts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_i && !err_o && !(req_valid_i && ready_o)) |=> outstanding_o == $past(outstanding_o) - 1'b1);

  assert_err_no_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(req_valid_i && ready_o)) |=> $stable(outstanding_o));

  assert_demand_le_total_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    demand_o <= outstanding_o);

  assert_deadlock_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deadlock_o |=> deadlock_o);
endmodule

bind omt_tracker omt_tracker_chk #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_type_i    (req_type_i),
  .ready_o       (ready_o),
  .accept_o      (accept_o),
  .cpl_valid_i   (cpl_valid_i),
  .err_o         (err_o),
  .outstanding_o (outstanding_o),
  .demand_o      (demand_o),
  .deadlock_o    (deadlock_o),
  .occ_sum_i     (occ_sum)
);

// File: tb/omt_tracker_tb.sv
module omt_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT   = 2;
  localparam int NE   = 4;
  localparam int AW   = 16;
  localparam int LG   = 4;
  localparam int MAXO = 6;
  localparam int WD   = 64;
  localparam int CW   = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_type = '0;
  logic          req_thread = 1'b0;
  logic          req_pf = 1'b0;
  logic          cpl_valid = 1'b0;
  logic [AW-1:0] cpl_addr = '0;
  logic          cpl_thread = 1'b0;
  logic          cpl_write = 1'b0;
  logic          ready, accept, err, deadlock;
  logic [CW-1:0] outstanding, demand;

  always #(CLK_PERIOD / 2) clk = ~clk;

  omt_tracker #(
    .NUM_THREADS(NT), .ENTRIES(NE), .ADDR_W(AW), .LINE_LG(LG),
    .MAX_OUT(MAXO), .WDOG_CYCLES(WD)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_type_i(req_type),
    .req_thread_i(req_thread), .req_pf_i(req_pf),
    .ready_o(ready), .accept_o(accept),
    .cpl_valid_i(cpl_valid), .cpl_addr_i(cpl_addr), .cpl_thread_i(cpl_thread),
    .cpl_write_i(cpl_write), .err_o(err),
    .outstanding_o(outstanding), .demand_o(demand), .deadlock_o(deadlock)
  );

  int nchk = 0;
  int nerr = 0;

  // scoreboard
  bit mv  [NT][2][NE];
  int mtag[NT][2][NE];
  bit mpf [NT][2][NE];
  int mcnt;
  bit warm, mdl;
  int wcnt;
  bit last_rdy, last_acc, last_err;

  task automatic chk(input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  function automatic int find(input int t, input int k, input int line);
    for (int s = 0; s < NE; s++)
      if (mv[t][k][s] && mtag[t][k][s] == line) return s;
    return -1;
  endfunction

  function automatic bit any_hit(input int line);
    for (int t = 0; t < NT; t++)
      for (int k = 0; k < 2; k++)
        if (find(t, k, line) >= 0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int occ(input int t, input int k);
    int n = 0;
    for (int s = 0; s < NE; s++) n += int'(mv[t][k][s]);
    return n;
  endfunction

  function automatic int mdem();
    int n = 0;
    for (int t = 0; t < NT; t++)
      for (int k = 0; k < 2; k++)
        for (int s = 0; s < NE; s++) n += int'(mv[t][k][s] && !mpf[t][k][s]);
    return n;
  endfunction

  task automatic model_clear();
    for (int t = 0; t < NT; t++)
      for (int k = 0; k < 2; k++)
        for (int s = 0; s < NE; s++) begin
          mv[t][k][s] = 1'b0; mtag[t][k][s] = 0; mpf[t][k][s] = 1'b0;
        end
    mcnt = 0; warm = 1'b0; wcnt = 0; mdl = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; cpl_valid = 1'b0;
    model_clear();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input bit rv, input int addr, input int typ, input int th, input bit pf,
                      input bit cv, input int caddr, input int cth, input bit cw);
    int line, cline, own, cs, fs, k;
    bit wr, erdy, coal, accn, cok;
    req_valid = rv; req_addr = AW'(addr); req_type = 2'(typ);
    req_thread = th[0]; req_pf = pf;
    cpl_valid = cv; cpl_addr = AW'(caddr); cpl_thread = cth[0]; cpl_write = cw;
    #1;
    line  = addr >> LG;
    cline = caddr >> LG;
    wr    = (typ >= 2);
    k     = wr ? 1 : 0;
    erdy  = (mcnt < MAXO) && !any_hit(line) && (occ(th, k) < NE);
    own   = wr ? find(th, 1, line) : -1;
    coal  = rv && wr && (own >= 0);
    accn  = rv && erdy;
    cs    = find(cth, cw ? 1 : 0, cline);
    cok   = cv && (cs >= 0);
    last_rdy = ready; last_acc = accept; last_err = err;
    chk("R3 ready", int'(ready), int'(erdy));
    chk("R4 accept", int'(accept), int'(accn || coal));
    chk("R7 err", int'(err), int'(cv && !cok));
    @(posedge clk);
    if (warm) begin
      if (wcnt == WD - 1) begin
        warm = 1'b0;
        if (mcnt != 0) mdl = 1'b1;
      end else wcnt++;
    end else if (accn || coal) begin
      warm = 1'b1; wcnt = 0;
    end
    if (coal) mpf[th][1][own] = pf;
    if (accn) begin
      fs = -1;
      for (int s = 0; s < NE; s++) if (fs < 0 && !mv[th][k][s]) fs = s;
      mv[th][k][fs] = 1'b1; mtag[th][k][fs] = line; mpf[th][k][fs] = pf;
    end
    if (cok) mv[cth][cw ? 1 : 0][cs] = 1'b0;
    mcnt = mcnt + int'(accn) - int'(cok);
    @(negedge clk);
    chk("R9 outstanding", int'(outstanding), mcnt);
    chk("R8 demand", int'(demand), mdem());
    chk("R10 deadlock", int'(deadlock), int'(mdl));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_clear();
    do_reset();
    #1;
    // R11 reset state
    chk("R11 ready after reset", int'(ready), 1);
    chk("R11 outstanding after reset", int'(outstanding), 0);
    chk("R11 demand after reset", int'(demand), 0);
    chk("R11 deadlock after reset", int'(deadlock), 0);
    @(negedge clk);

    // R2: same line from other thread with another offset is blocked
    step(1, 'h0103, 0, 0, 0, 0, 0, 0, 0);
    step(1, 'h010c, 0, 1, 0, 0, 0, 0, 0);
    chk("R2 other offset same line blocked", int'(last_rdy), 0);
    // R1: write completion does not match a load entry
    step(0, 0, 0, 0, 0, 1, 'h0100, 0, 1);
    chk("R1 write cpl vs read entry err", int'(last_err), 1);
    step(0, 0, 0, 0, 0, 1, 'h010f, 1, 0);
    chk("R7 wrong thread err", int'(last_err), 1);
    step(0, 0, 0, 0, 0, 1, 'h010f, 0, 0);
    chk("R6 read cpl frees", int'(outstanding), 0);
    // R1: ifetch goes to read table
    step(1, 'h0200, 1, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 'h0200, 1, 1);
    chk("R1 ifetch not in write table", int'(last_err), 1);
    step(0, 0, 0, 0, 0, 1, 'h0200, 1, 0);
    chk("R1 ifetch in read table", int'(last_err), 0);

    // R5: merge store flips prefetch flag, count unchanged
    step(1, 'h0300, 2, 0, 1, 0, 0, 0, 0);
    chk("R8 prefetch store not demand", int'(demand), 0);
    step(1, 'h0308, 3, 0, 0, 0, 0, 0, 0);
    chk("R5 merge accepted while not ready", int'(last_acc && !last_rdy), 1);
    chk("R5 merge keeps count", int'(outstanding), 1);
    chk("R5 merge updates flag", int'(demand), 1);
    step(1, 'h0300, 2, 1, 0, 0, 0, 0, 0);
    chk("R3 other thread store blocked", int'(last_acc), 0);
    // R12: merge and completion of the same entry together
    step(1, 'h0304, 2, 0, 1, 1, 'h0300, 0, 1);
    chk("R12 merge accepted", int'(last_acc), 1);
    chk("R12 entry freed", int'(outstanding), 0);

    // R3: table full, then global limit
    do_reset();
    for (int i = 1; i <= 4; i++) step(1, i << LG, 0, 0, 0, 0, 0, 0, 0);
    step(1, 5 << LG, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 full table blocks", int'(last_rdy), 0);
    step(1, 5 << LG, 1, 1, 0, 0, 0, 0, 0);
    step(1, 6 << LG, 2, 1, 0, 0, 0, 0, 0);
    chk("R9 at limit", int'(outstanding), MAXO);
    step(1, 7 << LG, 0, 1, 0, 0, 0, 0, 0);
    chk("R3 limit blocks", int'(last_rdy), 0);
    // R6: out-of-order completions
    step(0, 0, 0, 0, 0, 1, 3 << LG, 0, 0);
    step(0, 0, 0, 0, 0, 1, 6 << LG, 1, 1);
    step(0, 0, 0, 0, 0, 1, 1 << LG, 0, 0);
    chk("R6 out of order frees", int'(outstanding), 3);

    // R10: expiry with work pending
    do_reset();
    step(1, 'h0400, 0, 0, 0, 0, 0, 0, 0);
    idle(WD + 2);
    chk("R10 deadlock set", int'(deadlock), 1);
    idle(3);
    chk("R10 deadlock sticky", int'(deadlock), 1);
    // R10: expiry with empty tables
    do_reset();
    step(1, 'h0400, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 'h0400, 0, 0);
    idle(WD + 2);
    chk("R10 no deadlock when empty", int'(deadlock), 0);

    // random mix against the scoreboard
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int th, typ, addr, cth, caddr, ck, cs;
      bit rv, pf, cv, cw;
      th    = $urandom % NT;
      typ   = $urandom % 4;
      addr  = (($urandom % 6) << LG) | ($urandom % 16);
      rv    = ($urandom % 4) != 0;
      pf    = ($urandom % 4) == 0;
      cv    = ($urandom % 3) == 0;
      cth   = $urandom % NT;
      ck    = $urandom % 2;
      cs    = $urandom % NE;
      cw    = ck[0];
      caddr = mv[cth][ck][cs] ? ((mtag[cth][ck][cs] << LG) | ($urandom % 16))
                              : (($urandom % 6) << LG);
      step(rv, addr, typ, th, pf, cv, caddr, cth, cw);
      if (n % 1000 == 999) do_reset();
    end

    finish_run();
  end
endmodule